// File: doc/BRIEF.md
# Burst DRAM Access Sequencer

This block turns requests from a local processor bus into clock-counted row and column strobe sequences for a DRAM array built from one bank or two. A requester raises `reqValid` with an address and a burst flag and holds them until the controller acknowledges. A single read or write finishes in five clocks. A burst read fetches a 16-byte line as four 4-byte beats, paced five, one, one and one clocks.

A free-running interval timer schedules distributed refresh. A refresh is never allowed to break a line transfer, and it delays a waiting access by at most five clocks. A static mode input selects between two layouts. In the interleaved layout, consecutive 4-byte words alternate between the two banks. In the flat layout, a single bank holds every word.

A 3-bit capacity code sets the decoded array size. An address beyond that size is answered with an error pulse instead of memory strobes. A reserved code turns every access into an error.

Top module: `burst_dram_seq`

## Requirements
- R1: While reset is held, and in idle cycles after it, `ackBeat`, `errAck`, `rowStrobe`, `colStrobe`, `writeStrobe` and `refStrobe` are all low and `bankSel` is 00.
- R2: A burst read is taken when `reqBurst`=1 and `reqWrite`=0. If `reqValid` is first sampled in clock 1, `ackBeat` is high in clocks 5, 6, 7 and 8. Beat k presents word index (addr[3:2]+k) mod 4, and addr[ADDR_W-1:4] stays fixed for the whole line.
- R3: Any other access gives exactly one `ackBeat`, in clock 5. `writeStrobe` is high alongside that beat only when `reqWrite`=1. A write that also has `reqBurst`=1 is still a single transfer.
- R4: With no accesses, `refStrobe` goes high for exactly 5 consecutive clocks, and its rising edges are exactly 350 clocks apart.
- R5: A request whose first sample coincides with the start of a refresh gets its single ack in clock 10, which is no more than 5 clocks late.
- R6: A refresh that falls due during a burst waits. All four beats keep the 5-1-1-1 pacing, and `refStrobe` rises in the clock right after the last beat.
- R7: When `dualBank`=1, address bit 2 picks the bank: `bankSel`=01 for bank A when the bit is 0, and 10 for bank B when it is 1. `memWord` is then addr[MAX_LOG-1:3]. When `dualBank`=0, `bankSel` is 01 and `memWord` is addr[MAX_LOG-1:2]. `bankSel` is non-zero only during beats.
- R8: The capacity code 000/001/010/011 selects 32/16/8/4 MB, which is 2^(25-code) bytes. An address with any bit set at or above position 25-code gets `errAck` for one clock, in clock 2, and no row or column strobe.
- R9: A capacity code with bit 2 set answers every access with a one-clock `errAck` in clock 2 and no memory strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Access request, held until ack or error |
| reqAddr | input | ADDR_W | Byte address of the access |
| reqBurst | input | 1 | Request a 16-byte line read |
| reqWrite | input | 1 | Access is a write |
| dualBank | input | 1 | 1: two interleaved banks, 0: one bank |
| capCode | input | 3 | Array capacity code |
| ackBeat | output | 1 | One 4-byte beat completes this clock |
| errAck | output | 1 | Access refused (out of range or reserved code) |
| rowStrobe | output | 1 | Row strobe, high for the whole access |
| colStrobe | output | 1 | Column strobe, high on each beat |
| writeStrobe | output | 1 | Write enable on a write beat |
| refStrobe | output | 1 | Refresh cycle in progress |
| bankSel | output | 2 | One-hot bank select during beats |
| memWord | output | MAX_LOG-2 | In-bank word address for the current beat |

## Verification
Two events can land on the same clock: the refresh timer expiring and an access arriving or running. The bench locks onto one refresh rise and counts forward to the next. It places a request exactly on the clock where the next refresh starts, and judges the ack clock (10, never later). It places a burst so that the refresh falls due on its second beat, and judges that the beats remain back to back and that the refresh begins immediately after the fourth.

// File: rtl/burst_dram_seq_pkg.sv
package burst_dram_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ROW,
    ST_COLA,
    ST_COLB,
    ST_BEAT,
    ST_REF,
    ST_ERR
  } seqState_t;

  // strobes from the sequencer to the address path
  typedef struct packed {
    logic load;   // capture request address
    logic step;   // advance to next word of the line
    logic colOn;  // a beat is on the bus
  } pathCtl_t;

endpackage

// File: rtl/burst_dram_seq_ctrl.sv
module burst_dram_seq_ctrl
  import burst_dram_seq_pkg::*;
#(
  parameter int REF_PERIOD = 350,
  parameter int REF_CYC    = 5
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     reqValid,
  input  logic     reqBurst,
  input  logic     reqWrite,
  input  logic     capReserved,
  input  logic     rangeBad,
  output pathCtl_t ctl,
  output logic     ackBeat,
  output logic     errAck,
  output logic     rowStrobe,
  output logic     colStrobe,
  output logic     writeStrobe,
  output logic     refStrobe
);

  localparam int REF_W  = $clog2(REF_PERIOD);
  localparam int RCNT_W = $clog2(REF_CYC + 1);
  localparam int WAIT_W = $clog2(REF_CYC + 2);
  localparam logic [REF_W-1:0]  TIMER_LAST = REF_W'(REF_PERIOD - 1);
  localparam logic [RCNT_W-1:0] REF_LAST   = RCNT_W'(REF_CYC - 1);

  seqState_t state, nextState;
  logic [REF_W-1:0]  refTimer;
  logic [RCNT_W-1:0] refCnt;
  logic [WAIT_W-1:0] waitCnt;
  logic [1:0]        beatCnt;
  logic refPending, isBurst, isWrite;
  logic accessBad, lastBeat, timerWrap;

  assign accessBad = capReserved | rangeBad;
  assign lastBeat  = !isBurst || (beatCnt == 2'd3);
  assign timerWrap = (refTimer == TIMER_LAST);

  always_comb begin
    nextState = state;
    unique case (state)
      ST_IDLE: begin
        if (refPending)    nextState = ST_REF;
        else if (reqValid) nextState = accessBad ? ST_ERR : ST_ROW;
      end
      ST_ROW:  nextState = ST_COLA;
      ST_COLA: nextState = ST_COLB;
      ST_COLB: nextState = ST_BEAT;
      ST_BEAT: if (lastBeat) nextState = refPending ? ST_REF : ST_IDLE;
      ST_REF: begin
        if (refCnt == REF_LAST) begin
          if (reqValid) nextState = accessBad ? ST_ERR : ST_ROW;
          else          nextState = ST_IDLE;
        end
      end
      ST_ERR:  nextState = refPending ? ST_REF : ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      refTimer   <= '0;
      refPending <= 1'b0;
      refCnt     <= '0;
      beatCnt    <= '0;
      isBurst    <= 1'b0;
      isWrite    <= 1'b0;
      waitCnt    <= '0;
    end else begin
      state    <= nextState;
      refTimer <= timerWrap ? '0 : refTimer + 1'b1;
      if (timerWrap)                                  refPending <= 1'b1;
      else if (nextState == ST_REF && state != ST_REF) refPending <= 1'b0;
      refCnt <= (state == ST_REF) ? refCnt + 1'b1 : '0;
      if (nextState == ST_ROW) begin
        isBurst <= reqBurst & ~reqWrite;
        isWrite <= reqWrite;
        beatCnt <= '0;
      end else if (state == ST_BEAT) begin
        beatCnt <= beatCnt + 2'd1;
      end
      waitCnt <= (state == ST_REF && reqValid) ? waitCnt + 1'b1 : '0;
    end
  end

  assign ctl.load  = (nextState == ST_ROW);
  assign ctl.step  = (state == ST_BEAT) && !lastBeat;
  assign ctl.colOn = (state == ST_BEAT);

  assign ackBeat     = (state == ST_BEAT);
  assign colStrobe   = (state == ST_BEAT);
  assign writeStrobe = (state == ST_BEAT) && isWrite;
  assign errAck      = (state == ST_ERR);
  assign refStrobe   = (state == ST_REF);
  assign rowStrobe   = (state == ST_ROW) || (state == ST_COLA) ||
                       (state == ST_COLB) || (state == ST_BEAT);

  AST_FIRST_BEAT_LAT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rowStrobe) |-> ##3 ackBeat); // R2
  AST_BURST_STREAM: assert property (@(posedge clk) disable iff (!rstN)
    ackBeat && isBurst && beatCnt != 2'd3 |=> ackBeat); // R2
  AST_SINGLE_ONE_ACK: assert property (@(posedge clk) disable iff (!rstN)
    ackBeat && !isBurst |=> !ackBeat); // R3
  AST_REF_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    $rose(refStrobe) |-> ##(REF_CYC-1) refStrobe); // R4
  AST_REF_WAIT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    waitCnt <= WAIT_W'(REF_CYC)); // R5
  AST_REF_AFTER_LINE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(refStrobe) |-> !$past(rowStrobe) || $past(ackBeat)); // R6
  AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    errAck |=> !errAck && !rowStrobe); // R8

endmodule

// File: rtl/burst_dram_seq_path.sv
module burst_dram_seq_path
  import burst_dram_seq_pkg::*;
#(
  parameter int ADDR_W  = 26,
  parameter int MAX_LOG = 25
) (
  input  logic                clk,
  input  logic                rstN,
  input  pathCtl_t            ctl,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic                dualBank,
  input  logic [1:0]          capSize,
  output logic                rangeBad,
  output logic [1:0]          bankSel,
  output logic [MAX_LOG-3:0]  memWord
);

  localparam int WORD_W = MAX_LOG - 2;

  logic [WORD_W-1:0] curWord;

  // address bits at or above the decoded size make the access illegal
  always_comb begin
    int limitPos;
    limitPos = MAX_LOG - int'(capSize);
    rangeBad = 1'b0;
    for (int i = 0; i < ADDR_W; i++) begin
      if (i >= limitPos && reqAddr[i]) rangeBad = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curWord <= '0;
    end else if (ctl.load) begin
      curWord <= reqAddr[MAX_LOG-1:2];
    end else if (ctl.step) begin
      curWord[1:0] <= curWord[1:0] + 2'd1;
    end
  end

  always_comb begin
    if (!ctl.colOn)    bankSel = 2'b00;
    else if (dualBank) bankSel = curWord[0] ? 2'b10 : 2'b01;
    else               bankSel = 2'b01;
    memWord = dualBank ? WORD_W'(curWord[WORD_W-1:1]) : curWord;
  end

  AST_LINE_BASE_FIXED: assert property (@(posedge clk) disable iff (!rstN)
    ctl.step |=> curWord[WORD_W-1:2] == $past(curWord[WORD_W-1:2])); // R2
  AST_BANK_ALTERNATE: assert property (@(posedge clk) disable iff (!rstN)
    dualBank && ctl.colOn && $past(ctl.step) && $past(dualBank)
      |-> bankSel != $past(bankSel)); // R7

endmodule

// File: rtl/burst_dram_seq.sv
module burst_dram_seq
  import burst_dram_seq_pkg::*;
#(
  parameter int ADDR_W     = 26,
  parameter int MAX_LOG    = 25,
  parameter int REF_PERIOD = 350,
  parameter int REF_CYC    = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic [ADDR_W-1:0]  reqAddr,
  input  logic               reqBurst,
  input  logic               reqWrite,
  input  logic               dualBank,
  input  logic [2:0]         capCode,
  output logic               ackBeat,
  output logic               errAck,
  output logic               rowStrobe,
  output logic               colStrobe,
  output logic               writeStrobe,
  output logic               refStrobe,
  output logic [1:0]         bankSel,
  output logic [MAX_LOG-3:0] memWord
);

  pathCtl_t ctl;
  logic     rangeBad;

  burst_dram_seq_ctrl #(
    .REF_PERIOD(REF_PERIOD),
    .REF_CYC   (REF_CYC)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqBurst   (reqBurst),
    .reqWrite   (reqWrite),
    .capReserved(capCode[2]),
    .rangeBad   (rangeBad),
    .ctl        (ctl),
    .ackBeat    (ackBeat),
    .errAck     (errAck),
    .rowStrobe  (rowStrobe),
    .colStrobe  (colStrobe),
    .writeStrobe(writeStrobe),
    .refStrobe  (refStrobe)
  );

  burst_dram_seq_path #(
    .ADDR_W (ADDR_W),
    .MAX_LOG(MAX_LOG)
  ) u_path (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .reqAddr (reqAddr),
    .dualBank(dualBank),
    .capSize (capCode[1:0]),
    .rangeBad(rangeBad),
    .bankSel (bankSel),
    .memWord (memWord)
  );

endmodule

// File: tb/burst_dram_seq_tb.sv
module burst_dram_seq_tb;

  localparam int ADDR_W = 26;
  localparam int MAX_LOG = 25;
  localparam int WORD_W = MAX_LOG - 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic reqBurst = 1'b0;
  logic reqWrite = 1'b0;
  logic dualBank = 1'b0;
  logic [2:0] capCode = 3'b000;
  logic ackBeat, errAck, rowStrobe, colStrobe, writeStrobe, refStrobe;
  logic [1:0] bankSel;
  logic [WORD_W-1:0] memWord;

  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  burst_dram_seq u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqBurst(reqBurst), .reqWrite(reqWrite), .dualBank(dualBank),
    .capCode(capCode), .ackBeat(ackBeat), .errAck(errAck),
    .rowStrobe(rowStrobe), .colStrobe(colStrobe), .writeStrobe(writeStrobe),
    .refStrobe(refStrobe), .bankSel(bankSel), .memWord(memWord)
  );

  typedef struct packed {
    logic             burst;
    logic             wr;
    logic             dual;
    logic [2:0]       cap;
    logic [ADDR_W-1:0] addr;
    logic             err;
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 1'b0, 1'b0, 3'b011, 26'h000_0010, 1'b0},
    '{1'b1, 1'b0, 1'b0, 3'b000, 26'h000_0108, 1'b0},
    '{1'b1, 1'b0, 1'b1, 3'b001, 26'h000_2004, 1'b0},
    '{1'b0, 1'b1, 1'b1, 3'b010, 26'h07F_FFFC, 1'b0},
    '{1'b1, 1'b1, 1'b1, 3'b000, 26'h1FF_FFF0, 1'b0},
    '{1'b0, 1'b0, 1'b0, 3'b011, 26'h040_0000, 1'b1},
    '{1'b1, 1'b0, 1'b1, 3'b010, 26'h080_0000, 1'b1},
    '{1'b0, 1'b0, 1'b0, 3'b000, 26'h200_0000, 1'b1},
    '{1'b0, 1'b0, 1'b0, 3'b100, 26'h000_0000, 1'b1},
    '{1'b1, 1'b0, 1'b1, 3'b111, 26'h000_0040, 1'b1}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic idleOutputs(input string req);
    chk(!ackBeat && !errAck && !rowStrobe && !colStrobe && !writeStrobe &&
        !refStrobe && bankSel == 2'b00, req, "idle outputs",
        {ackBeat, errAck, rowStrobe, colStrobe, writeStrobe, refStrobe, bankSel}, 0);
  endtask

  task automatic syncRefRise();
    do @(negedge clk); while (!refStrobe);
  endtask

  task automatic waitRefDone();
    syncRefRise();
    do @(negedge clk); while (refStrobe);
  endtask

  // drive one access in clock 1 and check every beat against the rules
  task automatic runAccess(input vec_t v, input string tag, input int firstAck);
    int n, beats, expBeats;
    bit done;
    logic [WORD_W-1:0] w;
    logic [WORD_W-1:0] expWord;
    logic [1:0] expBank;
    dualBank = v.dual;
    capCode  = v.cap;
    reqAddr  = v.addr;
    reqBurst = v.burst;
    reqWrite = v.wr;
    reqValid = 1'b1;
    n = 1;
    beats = 0;
    done = 1'b0;
    expBeats = v.err ? 0 : ((v.burst && !v.wr) ? 4 : 1);
    while (!done && n < 30) begin
      @(negedge clk);
      n++;
      if (errAck) begin
        chk(v.err == 1'b1, tag, "error answer", 1, v.err);
        chk(n == 2, tag, "error clock", n, 2);
        chk(!rowStrobe && !colStrobe, tag, "strobes on error", rowStrobe, 0);
        done = 1'b1;
      end
      if (ackBeat) begin
        chk(n == firstAck + beats, tag, "beat clock", n, firstAck + beats);
        w = {v.addr[MAX_LOG-1:4], v.addr[3:2] + 2'(beats)};
        expWord = v.dual ? WORD_W'(w[WORD_W-1:1]) : w;
        expBank = (v.dual && w[0]) ? 2'b10 : 2'b01;
        chk(memWord == expWord, "R7", "memWord", memWord, expWord);
        chk(bankSel == expBank, "R7", "bankSel", bankSel, expBank);
        chk(writeStrobe == v.wr, "R3", "writeStrobe", writeStrobe, v.wr);
        beats++;
        if (beats == expBeats) done = 1'b1;
      end
    end
    reqValid = 1'b0;
    chk(done, tag, "access completed", done, 1);
    @(negedge clk);
    chk(!ackBeat && !errAck, tag, "no extra answer", {ackBeat, errAck}, 0);
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int cnt, width;
    string tag;
    // R1 reset and idle state
    repeat (3) @(negedge clk);
    idleOutputs("R1");
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    idleOutputs("R1");

    // R4 refresh width and spacing
    syncRefRise();
    width = 0;
    cnt = 0;
    while (refStrobe) begin width++; cnt++; @(negedge clk); end
    while (!refStrobe) begin cnt++; @(negedge clk); end
    chk(width == 5, "R4", "refresh width", width, 5);
    chk(cnt == 350, "R4", "refresh spacing", cnt, 350);

    // vector table: each access starts in a quiet window after a refresh
    for (int i = 0; i < NVEC; i++) begin
      waitRefDone();
      if (VECS[i].err) tag = VECS[i].cap[2] ? "R9" : "R8";
      else tag = (VECS[i].burst && !VECS[i].wr) ? "R2" : "R3";
      runAccess(VECS[i], tag, 5);
    end

    // R5 request lands on the clock the refresh starts
    syncRefRise();
    repeat (349) @(negedge clk);
    runAccess('{1'b0, 1'b0, 1'b0, 3'b000, 26'h000_0200, 1'b0}, "R5", 10);

    // R6 refresh falls due during a burst
    syncRefRise();
    repeat (345) @(negedge clk);
    runAccess('{1'b1, 1'b0, 1'b1, 3'b000, 26'h000_030C, 1'b0}, "R6", 5);
    chk(refStrobe == 1'b1, "R6", "refresh right after line", refStrobe, 1);

    // R9 again with a write under a reserved code
    waitRefDone();
    runAccess('{1'b0, 1'b1, 1'b0, 3'b101, 26'h000_0000, 1'b1}, "R9", 5);
    idleOutputs("R1");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule